// File: doc/BRIEF.md
# Delayed Power-Good Generator

This block drives a single power-good level for a processor. It watches two digitized supply measurements, a general detect channel and the 5 V rail channel. Each channel passes through a comparator with a rise level and a lower fall level. A channel counts as healthy once its code reaches the rise level, and it stays healthy until the code drops below the fall level.

Once both channels are healthy and the supervisor enable is high, a tick counter measures the qualification delay. Power-good goes high only after the programmed number of ticks has passed with no interruption. Any channel below its fall level, or a low enable, pulls power-good low on the next clock and clears the delay, so each new qualification starts from zero. Thresholds and hysteresis are parameters in ADC code units, and the delay is a parameter in ticks.

Top module: `pwr_good_gen`

## Requirements
- R1: While reset is asserted, and after its release with no qualification yet, `pg` is 0.
- R2: With both channels healthy and `en` high, `pg` stays 0 through the clock that samples the DELAY_TICKS-th `tick` pulse, and becomes 1 on the following clock edge.
- R3: A channel becomes healthy only when its code is at least LO+HYS (detect: 256+8=264, rail: 880+8=888 by default). A code at or above LO but below LO+HYS never qualifies, however many ticks pass. A code exactly at LO+HYS qualifies.
- R4: Once a channel is healthy, a code inside the band [LO, LO+HYS) keeps it healthy, and `pg` stays 1.
- R5: A code below LO on either channel (detect below 256, rail below 880) drives `pg` to 0 on the next clock edge.
- R6: After a drop, `pg` returns to 1 only after a full fresh DELAY_TICKS ticks counted from requalification.
- R7: `en` low drives `pg` to 0 on the next clock edge and holds it there. On re-enable the full delay restarts.
- R8: `tick` pulses that arrive while either channel is not healthy or `en` is low do not count toward the delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timing pulse for the delay counter |
| en | input | 1 | Supervisor enable; low forces power fail |
| det_code | input | CODE_W | Digitized detect channel measurement |
| v5_code | input | CODE_W | Digitized 5 V rail measurement |
| pg | output | 1 | Power-good level, 1 = good |

## Verification
The hardest condition to reach from the ports is a channel held inside its hysteresis band: the same code must qualify or fail to qualify depending on the path taken to reach it. The stimulus drives the rail into the band from below after a drop and supplies more ticks than the delay, then sets it exactly to the rise level. It also brings both channels down into the band from above while power-good is high. The delay edge is measured tick by tick, with `pg` sampled both after the last tick and one clock later.

// File: rtl/pg_pkg.sv
package pg_pkg;
   typedef enum logic {
      CH_LOW = 1'b0,
      CH_OK  = 1'b1
   } chan_st_e;
endpackage

// File: rtl/pg_hyst_cmp.sv
module pg_hyst_cmp
   import pg_pkg::*;
#(
   parameter int CODE_W = 10,
   parameter int LO     = 256,
   parameter int HYS    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code,
   output logic              healthy,
   output logic              below
);
   localparam int RISE_I = LO + HYS;
   localparam logic [CODE_W-1:0] FALL_C = CODE_W'(LO);
   localparam logic [CODE_W-1:0] RISE_C = CODE_W'(RISE_I);

   if (LO < 1)                  $error("pg_hyst_cmp: LO must be positive");
   if (HYS < 0)                 $error("pg_hyst_cmp: HYS must not be negative");
   if (RISE_I >= (1 << CODE_W)) $error("pg_hyst_cmp: LO+HYS exceeds code range");

   chan_st_e st_q;

   assign below = (code < FALL_C);

   if (HYS == 0) begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      st_q <= CH_LOW;
         else if (below)  st_q <= CH_LOW;
         else             st_q <= CH_OK;
      end
   end else begin : g_band
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              st_q <= CH_LOW;
         else if (below)          st_q <= CH_LOW;
         else if (code >= RISE_C) st_q <= CH_OK;
      end
   end

   assign healthy = (st_q == CH_OK);

   // R3
   rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(healthy) |-> ($past(code) >= RISE_C));

   // R5
   fall_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(healthy) |-> ($past(code) < FALL_C));
endmodule

// File: rtl/pg_delay_timer.sv
module pg_delay_timer #(
   parameter int DELAY_TICKS = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic tick,
   output logic done
);
   localparam int CNT_W = $clog2(DELAY_TICKS + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_TICKS);

   if (DELAY_TICKS < 1) $error("pg_delay_timer: DELAY_TICKS must be at least 1");

   logic [CNT_W-1:0] cnt_q;

   assign done = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clear)          cnt_q <= '0;
      else if (tick && !done)  cnt_q <= cnt_q + 1'b1;
   end

   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // R8
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clear) |-> (cnt_q == '0));
endmodule

// File: rtl/pwr_good_gen.sv
module pwr_good_gen #(
   parameter int CODE_W      = 10,
   parameter int DET_LO      = 256,
   parameter int DET_HYS     = 8,
   parameter int V5_LO       = 880,
   parameter int V5_HYS      = 8,
   parameter int DELAY_TICKS = 250
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              en,
   input  logic [CODE_W-1:0] det_code,
   input  logic [CODE_W-1:0] v5_code,
   output logic              pg
);
   if (CODE_W < 2) $error("pwr_good_gen: CODE_W too small");

   logic det_ok, det_below, v5_ok, v5_below;
   logic fail_now, qual, done;

   pg_hyst_cmp #(.CODE_W(CODE_W), .LO(DET_LO), .HYS(DET_HYS)) u_det (
      .clk(clk), .rst_n(rst_n), .code(det_code),
      .healthy(det_ok), .below(det_below));

   pg_hyst_cmp #(.CODE_W(CODE_W), .LO(V5_LO), .HYS(V5_HYS)) u_v5 (
      .clk(clk), .rst_n(rst_n), .code(v5_code),
      .healthy(v5_ok), .below(v5_below));

   assign fail_now = !en || det_below || v5_below;
   assign qual     = en && det_ok && v5_ok;

   pg_delay_timer #(.DELAY_TICKS(DELAY_TICKS)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clear(fail_now || !qual),
      .tick(tick), .done(done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pg <= 1'b0;
      else        pg <= !fail_now && qual && done;
   end

   // R2
   pg_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pg) |-> $past(done));

   // R7
   en_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en) |-> !pg);

   // R5
   det_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(det_below) |-> !pg);

   // R5
   v5_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(v5_below) |-> !pg);
endmodule

// File: tb/tb_pwr_good_gen.sv
`timescale 1ns/1ps
module tb_pwr_good_gen;
   localparam int W     = 10;
   localparam int DELAY = 250;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic en = 1'b0;
   logic [W-1:0] det_code = '0;
   logic [W-1:0] v5_code = '0;
   logic pg;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   pwr_good_gen #(.CODE_W(W), .DET_LO(256), .DET_HYS(8), .V5_LO(880),
      .V5_HYS(8), .DELAY_TICKS(DELAY)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(en),
      .det_code(det_code), .v5_code(v5_code), .pg(pg));

   task automatic check(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s pg actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
      end
   endtask

   task automatic settle;
      @(negedge clk);
   endtask

   // R2 / R6 / R8: full delay measured from a fresh qualification
   task automatic expect_full_delay(input string req);
      settle();
      do_ticks(DELAY - 1);
      check(req, pg, 1'b0);
      do_ticks(1);
      check(req, pg, 1'b0);
      @(negedge clk);
      check(req, pg, 1'b1);
   endtask

   task automatic t_reset;
      check("R1 during reset", pg, 1'b0);
      @(negedge clk) rst_n = 1'b1;
      do_ticks(3);
      check("R1 after reset", pg, 1'b0);
   endtask

   task automatic t_rise;
      @(negedge clk);
      det_code = 10'd300; v5_code = 10'd900; en = 1'b1;
      expect_full_delay("R2 rise");
   endtask

   task automatic t_band_hold;
      @(negedge clk);
      det_code = 10'd258; v5_code = 10'd882;
      do_ticks(5);
      check("R4 band hold", pg, 1'b1);
      det_code = 10'd256; v5_code = 10'd880;
      do_ticks(2);
      check("R4 at LO", pg, 1'b1);
   endtask

   task automatic t_drop_det;
      @(negedge clk) det_code = 10'd255;
      @(negedge clk);
      check("R5 detect drop", pg, 1'b0);
      det_code = 10'd300; v5_code = 10'd900;
      expect_full_delay("R6 restart after detect drop");
   endtask

   task automatic t_drop_v5_band;
      @(negedge clk) v5_code = 10'd879;
      @(negedge clk);
      check("R5 rail drop", pg, 1'b0);
      v5_code = 10'd884;
      do_ticks(DELAY + 5);
      check("R3 band no qualify", pg, 1'b0);
      v5_code = 10'd888;
      expect_full_delay("R8 R3 exact rise level");
   endtask

   task automatic t_enable;
      @(negedge clk) en = 1'b0;
      @(negedge clk);
      check("R7 enable low", pg, 1'b0);
      do_ticks(DELAY + 2);
      check("R7 held low", pg, 1'b0);
      en = 1'b1;
      expect_full_delay("R7 re-enable");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_rise();
      t_band_hold();
      t_drop_det();
      t_drop_v5_band();
      t_enable();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule